// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block steps a microprogrammed control unit through a writable control store of 128 words, each 20 bits wide. A 7-bit control address register selects the word being executed. The word's condition-select field picks one status condition, taken from the data register input or the accumulator input. The word's branch-type field then decides the next control address. The choices are: the next sequential word, the word's own 7-bit target, a target taken together with a saved return link, the saved link itself, or an address formed from the opcode bits of the data register.

A single-level return register holds the link for one subroutine call. The three 3-bit micro-operation fields of the addressed word are presented on registered outputs for downstream datapath logic. This block does not carry out those micro-operations.

Loading works as follows. Software or a boot engine raises the halt input and writes words through the load port, then drops halt to let the sequencer run. While halt is high the sequencer does not advance.

Top module: `mseq_core`

## Requirements
- R1: A control word is laid out from the most significant bit as op field A [19:17], op field B [16:14], op field C [13:11], condition select [10:9], branch type [8:7], target address [6:0]; op fields A, B and C appear on uop1_o, uop2_o and uop3_o.
- R2: Condition select 00 gives true, 01 gives dr_i[15], 10 gives ac_i[15], and 11 gives true exactly when ac_i is all zeros.
- R3: Branch type 00 moves the control address to the target when the condition is true and to the control address plus one (modulo 128) otherwise.
- R4: Branch type 01 with a true condition moves the control address to the target and stores the control address plus one (modulo 128) in the return register; with a false condition it only increments the control address. No other branch type and no halted cycle changes the return register.
- R5: Branch type 10 moves the control address to the value in the return register.
- R6: Branch type 11 moves the control address to {0, dr_i[14:11], 00}.
- R7: While halt_i is high the control address and return register do not change, and the op outputs show the fields of the word at the current control address one cycle after any write to that word.
- R8: A load-port write only changes the control store when halt_i is high in the same cycle; writes while running are ignored.
- R9: Synchronous reset clears the control address, the return register and the three op outputs to zero.
- R10: After every running clock edge the op outputs carry the fields of the word at the newly loaded control address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Freezes sequencing and enables store writes |
| ld_we_i | input | 1 | Load-port write strobe |
| ld_addr_i | input | 7 | Load-port word address |
| ld_word_i | input | 20 | Load-port control word |
| dr_i | input | 16 | Data register value: sign condition and opcode bits |
| ac_i | input | 16 | Accumulator value: sign and zero conditions |
| uop1_o | output | 3 | Op field A of the addressed word |
| uop2_o | output | 3 | Op field B of the addressed word |
| uop3_o | output | 3 | Op field C of the addressed word |

## Verification
The bench builds the sequencer with its package defaults: a 7-bit control address, a full 128-word store and 16-bit status inputs. Each of eight passes fills every store word with a computed program. In each word the op fields encode that word's own address, so the outputs reveal the control address. The condition and branch fields vary from word to word, so every condition code meets every branch type, including wrap from address 127. Status inputs change every cycle with a zero accumulator every fourth cycle. Mid-run halts and a write attempted while running bring the freeze and ignored-write rules within reach.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int ADDR_W    = 7;
    localparam int FLD_W     = 3;
    localparam int SEL_W     = 2;
    localparam int DATA_W    = 16;
    localparam int WORD_W    = 3 * FLD_W + 2 * SEL_W + ADDR_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SIGN_BIT  = DATA_W - 1;
    localparam int OPC_HI    = 14;
    localparam int OPC_LO    = 11;
    localparam int OPC_W     = OPC_HI - OPC_LO + 1;
    localparam int MAP_SHIFT = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [FLD_W-1:0]  fld_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [SEL_W-1:0] {
        CD_TRUE   = 2'b00,
        CD_DRSIGN = 2'b01,
        CD_ACSIGN = 2'b10,
        CD_ACZERO = 2'b11
    } cd_e;

    typedef enum logic [SEL_W-1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_e;

    // Packed MSB first: op A, op B, op C, condition, branch, target
    typedef struct packed {
        fld_t  opa;
        fld_t  opb;
        fld_t  opc;
        cd_e   cd;
        br_e   br;
        addr_t ad;
    } uword_t;

    function automatic addr_t addr_inc(input addr_t a);
        return a + addr_t'(1);
    endfunction

    function automatic addr_t map_addr(input data_t dr);
        addr_t a;
        a = '0;
        a[MAP_SHIFT +: OPC_W] = dr[OPC_HI:OPC_LO];
        return a;
    endfunction

endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
(
    input  logic   clk,
    input  logic   wr_en,
    input  addr_t  wr_addr,
    input  uword_t wr_word,
    input  addr_t  rd_addr_a,
    output uword_t rd_word_a,
    input  addr_t  rd_addr_b,
    output uword_t rd_word_b
);

    uword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Port A: word being executed; port B: word about to be addressed
    assign rd_word_a = mem[rd_addr_a];
    assign rd_word_b = mem[rd_addr_b];

endmodule

// File: rtl/mseq_cond.sv
module mseq_cond
    import mseq_pkg::*;
(
    input  cd_e   sel,
    input  data_t dr,
    input  data_t ac,
    output logic  hit
);

    always_comb begin
        unique case (sel)
            CD_TRUE:   hit = 1'b1;
            CD_DRSIGN: hit = dr[SIGN_BIT];
            CD_ACSIGN: hit = ac[SIGN_BIT];
            CD_ACZERO: hit = ~|ac;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  uword_t word,
    input  logic   hit,
    input  addr_t  car,
    input  addr_t  link,
    input  data_t  dr,
    output addr_t  nxt,
    output logic   link_we,
    output addr_t  link_nxt
);

    addr_t seq;

    always_comb begin
        seq      = addr_inc(car);
        nxt      = seq;
        link_we  = 1'b0;
        link_nxt = seq;
        unique case (word.br)
            BR_JUMP: if (hit) nxt = word.ad;
            BR_CALL: if (hit) begin
                nxt     = word.ad;
                link_we = 1'b1;
            end
            BR_RET:  nxt = link;
            BR_MAP:  nxt = map_addr(dr);
            default: nxt = seq;
        endcase
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_i,
    input  logic              ld_we_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [WORD_W-1:0] ld_word_i,
    input  logic [DATA_W-1:0] dr_i,
    input  logic [DATA_W-1:0] ac_i,
    output logic [FLD_W-1:0]  uop1_o,
    output logic [FLD_W-1:0]  uop2_o,
    output logic [FLD_W-1:0]  uop3_o
);

    addr_t  car_q, car_d, link_q, nxt, link_nxt;
    uword_t cur_w, nxt_w;
    logic   hit, link_we;
    fld_t   opa_q, opb_q, opc_q;

    mseq_store u_store (
        .clk       (clk),
        .wr_en     (ld_we_i & halt_i),
        .wr_addr   (ld_addr_i),
        .wr_word   (uword_t'(ld_word_i)),
        .rd_addr_a (car_q),
        .rd_word_a (cur_w),
        .rd_addr_b (car_d),
        .rd_word_b (nxt_w)
    );

    mseq_cond u_cond (
        .sel (cur_w.cd),
        .dr  (dr_i),
        .ac  (ac_i),
        .hit (hit)
    );

    mseq_next u_next (
        .word     (cur_w),
        .hit      (hit),
        .car      (car_q),
        .link     (link_q),
        .dr       (dr_i),
        .nxt      (nxt),
        .link_we  (link_we),
        .link_nxt (link_nxt)
    );

    assign car_d = halt_i ? car_q : nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q  <= '0;
            link_q <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            opc_q  <= '0;
        end else begin
            car_q <= car_d;
            if (!halt_i && link_we) begin
                link_q <= link_nxt;
            end
            opa_q <= nxt_w.opa;
            opb_q <= nxt_w.opb;
            opc_q <= nxt_w.opc;
        end
    end

    assign uop1_o = opa_q;
    assign uop2_o = opb_q;
    assign uop3_o = opc_q;

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (car_q == '0 && link_q == '0 && uop1_o == '0 && uop2_o == '0 && uop3_o == '0));

    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> (car_q == $past(car_q) && link_q == $past(link_q)));

    p_jump_target_r3: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && cur_w.br == BR_JUMP) |=>
            car_q == ($past(hit) ? $past(cur_w.ad) : addr_t'($past(car_q) + addr_t'(1))));

    p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && cur_w.br == BR_CALL && hit) |=>
            (link_q == addr_t'($past(car_q) + addr_t'(1)) && car_q == $past(cur_w.ad)));

    p_link_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (halt_i || cur_w.br != BR_CALL) |=> $stable(link_q));

    p_return_r5: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && cur_w.br == BR_RET) |=> car_q == $past(link_q));

    p_map_form_r6: assert property (@(posedge clk) disable iff (rst)
        (!halt_i && cur_w.br == BR_MAP) |=>
            (car_q[ADDR_W-1] == 1'b0 && car_q[MAP_SHIFT-1:0] == '0 &&
             car_q[MAP_SHIFT +: OPC_W] == $past(dr_i[OPC_HI:OPC_LO])));

endmodule

// File: tb/mseq_core_test.sv
module mseq_core_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        halt;
    logic        ld_we;
    logic [6:0]  ld_addr;
    logic [19:0] ld_word;
    logic [15:0] dr, ac;
    logic [2:0]  uop1, uop2, uop3;

    always #10 clk = ~clk;

    mseq_core uut (
        .clk       (clk),
        .rst       (rst),
        .halt_i    (halt),
        .ld_we_i   (ld_we),
        .ld_addr_i (ld_addr),
        .ld_word_i (ld_word),
        .dr_i      (dr),
        .ac_i      (ac),
        .uop1_o    (uop1),
        .uop2_o    (uop2),
        .uop3_o    (uop3)
    );

    int          n_run  = 0;
    int          n_fail = 0;
    logic [6:0]  mcar, mlink;
    logic [19:0] img [128];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // R1: op fields carry {01, own address} so outputs expose the control address
    function automatic logic [8:0] tag(input logic [6:0] a);
        return {2'b01, a};
    endfunction

    function automatic logic [19:0] mk(input int a, input int seed);
        int t1, t2, t3;
        t1 = a * 7 + seed * 3;
        t2 = (a * 13 + seed * 5) >> 2;
        t3 = a * 37 + seed * 11 + 5;
        return {2'b01, a[6:0], t1[1:0], t2[1:0], t3[6:0]};
    endfunction

    task automatic check_car(input string why);
        logic [8:0] obs;
        obs = {uop1, uop2, uop3};
        chk(obs == tag(mcar), why, 32'(obs), 32'(tag(mcar)));
    endtask

    function automatic void predict(input logic [15:0] d, input logic [15:0] a,
                                    output logic [6:0] nc, output logic [6:0] nl,
                                    output string why);
        logic [19:0] w;
        logic        c;
        w  = img[mcar];
        nl = mlink;
        case (w[10:9])
            2'b00:   c = 1'b1;
            2'b01:   c = d[15];
            2'b10:   c = a[15];
            default: c = (a == 16'h0000);
        endcase
        case (w[8:7])
            2'b00: begin
                nc  = c ? w[6:0] : mcar + 7'd1;
                why = "R3 R2 jump";
            end
            2'b01: begin
                if (c) begin
                    nc = w[6:0];
                    nl = mcar + 7'd1;
                end else begin
                    nc = mcar + 7'd1;
                end
                why = "R4 R2 call";
            end
            2'b10: begin
                nc  = mlink;
                why = "R5 return";
            end
            default: begin
                nc  = {1'b0, d[14:11], 2'b00};
                why = "R6 map";
            end
        endcase
        why = {why, " R10 R1 outputs"};
    endfunction

    initial begin
        rst = 1'b1; halt = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_word = '0;
        dr = '0; ac = '0;
        mcar = '0; mlink = '0;
        for (int seed = 0; seed < 8; seed++) begin
            @(negedge clk);
            rst = 1'b1; halt = 1'b0; ld_we = 1'b0;
            repeat (2) @(negedge clk);
            chk({uop1, uop2, uop3} == 9'h000, "R9 reset clears op outputs",
                32'({uop1, uop2, uop3}), 32'h0);
            rst = 1'b0; halt = 1'b1;
            mcar = '0; mlink = '0;
            for (int a = 0; a < 128; a++) begin
                ld_we   = 1'b1;
                ld_addr = 7'(a);
                ld_word = mk(a, seed);
                img[a]  = mk(a, seed);
                @(negedge clk);
            end
            ld_we = 1'b0;
            @(negedge clk);
            check_car("R9 R7 address zero after reset, halted outputs show word");
            for (int k = 0; k < 200; k++) begin
                logic [6:0] nc, nl;
                string      why;
                dr   = 16'(k * 27459) ^ 16'(seed * 4097);
                ac   = ((k % 4) == 0) ? 16'h0000 : 16'(k * 40503 + seed);
                halt = (k >= 60 && k < 64);
                predict(dr, ac, nc, nl, why);
                if (halt) begin
                    nc  = mcar;
                    nl  = mlink;
                    why = "R7 halt freezes sequencing";
                end
                if (k == 31) why = {why, " R8 running write ignored"};
                if (k == 30) begin
                    ld_we   = 1'b1;
                    ld_addr = nc;
                    ld_word = {9'h000, 2'b00, 2'b00, nc ^ 7'h40};
                end else begin
                    ld_we = 1'b0;
                end
                @(negedge clk);
                mcar  = nc;
                mlink = nl;
                check_car(why);
            end
            halt  = 1'b0;
            ld_we = 1'b0;
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule